// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Unit

This block supplies instructions to a core that can run with 16-bit compressed instructions enabled. The core hands it a fetch address and a compressed-mode flag. The unit returns a 32-bit instruction word and a flag that says whether the instruction is a 16-bit one. It reads from an already translated memory port that returns aligned 32-bit words, with one read outstanding at a time.

Fetches that are word aligned, and all fetches made with compressed mode off, go through a small direct-mapped fetch cache. A hit is served without touching memory. A miss reads one word and installs it in the entry. A fetch in compressed mode whose address sits at a halfword offset goes around the cache. The unit reads the halfword at the fetch address and tests it for a compressed encoding. Only when that halfword is not compressed does it read the following halfword from the next word and join the two. A flush input invalidates every cache entry at once.

Top module: `cfetch_unit`

## Requirements
- R1: A fetch takes the cache path when compressed mode is off or the address has bits [1:0] equal to 00. A compressed-mode fetch with address bit 1 set takes the split path, which never installs anything in the cache.
- R2: On the split path the unit first reads the word at the fetch address with bits [1:0] cleared and takes its bits [31:16] as the low halfword. If that halfword is compressed, the unit returns it zero-extended in the low 16 bits with the short flag set, after exactly one memory read.
- R3: If the low halfword on the split path is not compressed, the unit reads the next word (word address plus 4). It returns that word's bits [15:0] in bits [31:16], above the first halfword, with the short flag clear, after exactly two memory reads.
- R4: The cache has 256 direct-mapped entries indexed by address bits [9:2]. An entry hits only when it is valid and its stored tag equals the whole fetch address. A hit issues no memory read, and the instruction becomes valid after the second rising edge that follows acceptance of the request.
- R5: A cache miss issues one memory read of the aligned word and writes both the tag and the data into the entry, so the next fetch of the same address hits.
- R6: Two addresses that share an index evict each other.
- R7: A flush pulse invalidates every entry, so fetches made after it miss.
- R8: A flush that arrives while a miss is in flight stops that miss from installing its entry, so the next fetch of that address misses again.
- R9: While reset is held, the outputs are: no instruction valid, no memory request, and ready for a request. After reset every entry is invalid.
- R10: On the cache path the full 32-bit word is returned. The short flag is set exactly when compressed mode is on and data bits [1:0] are not 11 (a halfword is compressed when its bits [1:0] are not 11).
- R11: A presented instruction keeps its valid, data and short flag unchanged until it is accepted. No new request is accepted until then.
- R12: A memory request keeps its valid and address steady until the memory accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Unit can accept a fetch request |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_cmode | input | 1 | Compressed instructions enabled for this fetch |
| flush | input | 1 | Invalidate the whole fetch cache |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data word |
| insn_valid | output | 1 | Instruction present |
| insn_ready | input | 1 | Consumer takes the instruction |
| insn_data | output | 32 | Instruction word |
| insn_short | output | 1 | Instruction is a 16-bit encoding |

## Verification
A stale or missing valid bit shows up at the memory port on the very next fetch of the affected address. It appears as an unexpected read, or as a read that should have happened but did not, and the hit latency of two edges shifts with it. A wrong tag or a misdirected fill returns another word's data to the consumer as soon as that entry is hit. The most telling cases are aliasing indices and halfword-offset fetches that differ from a cached word only in bit 1. A fault in the split-path state is visible within one fetch: in the count of memory reads, in the address of the second read, or in how the two halves are placed and the short flag is set.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_LO_REQ,
    ST_LO_WAIT,
    ST_HI_REQ,
    ST_HI_WAIT,
    ST_OUT
  } fetch_state_e;

  // a halfword is a 16-bit encoding unless its two low bits are both set
  function automatic logic is_short(input logic [15:0] half);
    return half[1:0] != 2'b11;
  endfunction

endpackage

// File: rtl/cfu_line_ram.sv
module cfu_line_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store_q [DEPTH];

  // plain synchronous write/read so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
    if (re) rdata <= store_q[raddr];
  end

endmodule

// File: rtl/cfu_valid_array.sv
module cfu_valid_array #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);

  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q <= '0;
    end else if (set_en) begin
      vld_q[set_idx] <= 1'b1;
    end
  end

  // a lookup in the same cycle as a clear sees an empty cache
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
    end else if (rd_en) begin
      rd_valid <= vld_q[rd_idx] & ~clr;
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (vld_q == '0)); // R7

endmodule

// File: rtl/cfetch_unit.sv
module cfetch_unit #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int INSN_W  = 32,
  localparam int HALF_W  = INSN_W / 2,
  localparam int ENTRY_W = ADDR_W + INSN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_cmode,
  input  logic              flush,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [INSN_W-1:0] mem_rsp_data,
  output logic              insn_valid,
  input  logic              insn_ready,
  output logic [INSN_W-1:0] insn_data,
  output logic              insn_short
);
  import cfu_pkg::*;

  fetch_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cmode_q;
  logic              kill_q;
  logic [HALF_W-1:0] lo_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [INSN_W-1:0] insn_data_q;
  logic              insn_short_q;

  logic               accept;
  logic               split_now;
  logic               ram_re;
  logic               fill_we;
  logic [ENTRY_W-1:0] ram_q;
  logic               line_valid;
  logic               hit;
  logic [ADDR_W-1:0]  word_now;
  logic [ADDR_W-1:0]  word_held;
  logic [HALF_W-1:0]  rsp_hi_half;

  assign fetch_ready   = (state_q == ST_IDLE);
  assign insn_valid    = (state_q == ST_OUT);
  assign insn_data     = insn_data_q;
  assign insn_short    = insn_short_q;
  assign mem_req_valid = (state_q == ST_FILL_REQ) || (state_q == ST_LO_REQ) ||
                         (state_q == ST_HI_REQ);
  assign mem_req_addr  = mem_addr_q;

  assign accept      = fetch_valid && fetch_ready;
  assign split_now   = fetch_cmode && fetch_addr[1];
  assign ram_re      = accept && !split_now;
  assign word_now    = {fetch_addr[ADDR_W-1:2], 2'b00};
  assign word_held   = {addr_q[ADDR_W-1:2], 2'b00};
  assign rsp_hi_half = mem_rsp_data[INSN_W-1:HALF_W];

  // a fill is dropped when a flush arrives with it or earlier in the same miss
  assign fill_we = (state_q == ST_FILL_WAIT) && mem_rsp_valid && !kill_q && !flush;

  cfu_line_ram #(
    .DEPTH (ENTRIES),
    .WIDTH (ENTRY_W)
  ) u_line_ram (
    .clk   (clk),
    .we    (fill_we),
    .waddr (addr_q[2 +: IDX_W]),
    .wdata ({addr_q, mem_rsp_data}),
    .re    (ram_re),
    .raddr (fetch_addr[2 +: IDX_W]),
    .rdata (ram_q)
  );

  cfu_valid_array #(
    .DEPTH (ENTRIES)
  ) u_valid_array (
    .clk      (clk),
    .rst      (rst),
    .clr      (flush),
    .set_en   (fill_we),
    .set_idx  (addr_q[2 +: IDX_W]),
    .rd_en    (ram_re),
    .rd_idx   (fetch_addr[2 +: IDX_W]),
    .rd_valid (line_valid)
  );

  assign hit = line_valid && (ram_q[ENTRY_W-1:INSN_W] == addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_q <= 1'b0;
    end else if (accept) begin
      kill_q <= 1'b0;
    end else if (flush && (state_q != ST_IDLE)) begin
      kill_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      cmode_q      <= 1'b0;
      lo_q         <= '0;
      mem_addr_q   <= '0;
      insn_data_q  <= '0;
      insn_short_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q     <= fetch_addr;
            cmode_q    <= fetch_cmode;
            mem_addr_q <= word_now;
            state_q    <= split_now ? ST_LO_REQ : ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            insn_data_q  <= ram_q[INSN_W-1:0];
            insn_short_q <= cmode_q && is_short(ram_q[HALF_W-1:0]);
            state_q      <= ST_OUT;
          end else begin
            mem_addr_q <= word_held;
            state_q    <= ST_FILL_REQ;
          end
        end
        ST_FILL_REQ: begin
          if (mem_req_ready) state_q <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: begin
          if (mem_rsp_valid) begin
            insn_data_q  <= mem_rsp_data;
            insn_short_q <= cmode_q && is_short(mem_rsp_data[HALF_W-1:0]);
            state_q      <= ST_OUT;
          end
        end
        ST_LO_REQ: begin
          if (mem_req_ready) state_q <= ST_LO_WAIT;
        end
        ST_LO_WAIT: begin
          if (mem_rsp_valid) begin
            if (is_short(rsp_hi_half)) begin
              insn_data_q  <= {{HALF_W{1'b0}}, rsp_hi_half};
              insn_short_q <= 1'b1;
              state_q      <= ST_OUT;
            end else begin
              lo_q       <= rsp_hi_half;
              mem_addr_q <= word_held + ADDR_W'(4);
              state_q    <= ST_HI_REQ;
            end
          end
        end
        ST_HI_REQ: begin
          if (mem_req_ready) state_q <= ST_HI_WAIT;
        end
        ST_HI_WAIT: begin
          if (mem_rsp_valid) begin
            insn_data_q  <= {mem_rsp_data[HALF_W-1:0], lo_q};
            insn_short_q <= 1'b0;
            state_q      <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (insn_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SPLIT_NEVER_FILLS: assert property (@(posedge clk) disable iff (rst)
    fill_we |-> !(cmode_q && addr_q[1])); // R1

  AST_SHORT_HALF_ZEROED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LO_WAIT && mem_rsp_valid && is_short(rsp_hi_half))
      |=> insn_valid && insn_short && (insn_data[INSN_W-1:HALF_W] == '0)); // R2

  AST_JOIN_PLACES_HALVES: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HI_WAIT && mem_rsp_valid)
      |=> insn_valid && !insn_short && (insn_data[HALF_W-1:0] == lo_q)); // R3

  AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK && hit) |=> insn_valid && !mem_req_valid); // R4

  AST_SHORT_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_short) |-> (insn_data[1:0] != 2'b11)); // R10

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && !insn_ready)
      |=> insn_valid && $stable(insn_data) && $stable(insn_short)); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready)
      |=> mem_req_valid && $stable(mem_req_addr)); // R12

endmodule

// File: tb/cfetch_unit_bench.sv
`timescale 1ns/1ps
module cfetch_unit_bench;

  localparam int ADDR_W = 32;

  typedef struct packed {
    logic [31:0] addr;
    logic        cmode;
    logic [1:0]  reads;
  } vec_t;

  // stimulus and expected memory reads, walked in order from a cold cache
  localparam vec_t VEC [14] = '{
    '{32'h0000_1000, 1'b0, 2'd1},
    '{32'h0000_1000, 1'b0, 2'd0},
    '{32'h0000_1000, 1'b1, 2'd0},
    '{32'h0000_1020, 1'b1, 2'd1},
    '{32'h0000_1002, 1'b1, 2'd1},
    '{32'h0000_1042, 1'b1, 2'd2},
    '{32'h0000_1002, 1'b1, 2'd1},
    '{32'h0000_1400, 1'b0, 2'd1},
    '{32'h0000_1000, 1'b0, 2'd1},
    '{32'h0000_1020, 1'b0, 2'd0},
    '{32'h0000_13FC, 1'b0, 2'd1},
    '{32'h0000_13FC, 1'b0, 2'd0},
    '{32'h0000_1042, 1'b0, 2'd1},
    '{32'h0000_1042, 1'b0, 2'd0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fetch_valid = 1'b0;
  logic              fetch_ready;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic              fetch_cmode = 1'b0;
  logic              flush = 1'b0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b1;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [31:0]       mem_rsp_data = '0;
  logic              insn_valid;
  logic              insn_ready = 1'b0;
  logic [31:0]       insn_data;
  logic              insn_short;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int mem_lat = 0;
  int flush_at = 0;
  bit stall_mode = 1'b0;
  bit acc_pend = 1'b0;
  bit busy = 1'b0;
  int wait_n = 0;
  logic [31:0] acc_addr = '0;
  logic [31:0] cur_addr = '0;

  always #2.5 clk = ~clk;

  cfetch_unit u_cfetch_unit (
    .clk           (clk),
    .rst           (rst),
    .fetch_valid   (fetch_valid),
    .fetch_ready   (fetch_ready),
    .fetch_addr    (fetch_addr),
    .fetch_cmode   (fetch_cmode),
    .flush         (flush),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .insn_valid    (insn_valid),
    .insn_ready    (insn_ready),
    .insn_data     (insn_data),
    .insn_short    (insn_short)
  );

  // memory contents: low-bit tags chosen by address bits 5 and 6
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [15:0] lo;
    logic [15:0] hi;
    lo = {a[13:2], 2'b00, (a[5] ? 2'b11 : 2'b01)};
    hi = {a[17:4] ^ 14'h2A5C, (a[6] ? 2'b11 : 2'b10)};
    return {hi, lo};
  endfunction

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      acc_pend = 1'b1;
      acc_addr = mem_req_addr;
      rd_count = rd_count + 1;
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (busy) begin
      if (wait_n == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(cur_addr);
        busy = 1'b0;
      end else begin
        wait_n = wait_n - 1;
      end
    end
    if (acc_pend) begin
      acc_pend = 1'b0;
      busy     = 1'b1;
      cur_addr = acc_addr;
      wait_n   = mem_lat;
    end
    mem_req_ready = stall_mode ? ~mem_req_ready : 1'b1;
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %08h expected %08h", rq, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] addr, input logic cm, input int exp_reads,
                          input int hold_n, input string rq);
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] exp_data;
    logic        exp_short;
    int          r0;
    int          cyc;
    w0 = mem_word({addr[31:2], 2'b00});
    if (cm && addr[1]) begin
      if (w0[17:16] != 2'b11) begin
        exp_data  = {16'h0000, w0[31:16]};
        exp_short = 1'b1;
      end else begin
        w1 = mem_word({addr[31:2], 2'b00} + 32'd4);
        exp_data  = {w1[15:0], w0[31:16]};
        exp_short = 1'b0;
      end
    end else begin
      exp_data  = w0;
      exp_short = cm && (w0[1:0] != 2'b11);
    end
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = addr;
    fetch_cmode = cm;
    r0 = rd_count;
    @(negedge clk);
    fetch_valid = 1'b0;
    cyc = 1;
    while (!insn_valid && cyc < 200) begin
      flush = (cyc == flush_at);
      @(negedge clk);
      cyc = cyc + 1;
    end
    flush = 1'b0;
    check(insn_valid, {rq, " fetch completes"}, 32'(cyc), 32'd0);
    check(insn_data == exp_data, {rq, " data"}, insn_data, exp_data);
    check(insn_short == exp_short, {rq, " short flag"}, 32'(insn_short), 32'(exp_short));
    check((rd_count - r0) == exp_reads, {rq, " memory reads"}, 32'(rd_count - r0),
          32'(exp_reads));
    if (exp_reads == 0)
      check(cyc == 2, {rq, " hit latency"}, 32'(cyc), 32'd2);
    for (int h = 0; h < hold_n; h++) begin
      @(negedge clk);
      check(insn_valid && (insn_data == exp_data) && !fetch_ready, "R11 output held",
            insn_data, exp_data);
    end
    insn_ready = 1'b1;
    @(negedge clk);
    insn_ready = 1'b0;
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0:       return "R5 cold miss";
      1:       return "R4 hit";
      2:       return "R10 hit in compressed mode";
      3:       return "R10 miss not compressed";
      4:       return "R2 split compressed";
      5:       return "R3 split joined";
      6:       return "R1 split bypasses cache";
      7:       return "R6 alias evicts";
      8:       return "R6 evicted refill";
      9:       return "R4 tag ignores mode";
      10:      return "R4 top index miss";
      11:      return "R4 top index hit";
      12:      return "R1 split left no entry";
      default: return "R5 refill hit";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(!insn_valid, "R9 reset insn_valid", 32'(insn_valid), 32'd0);
    check(!mem_req_valid, "R9 reset mem_req_valid", 32'(mem_req_valid), 32'd0);
    check(fetch_ready, "R9 reset fetch_ready", 32'(fetch_ready), 32'd1);
    rst = 1'b0;

    for (int i = 0; i < 14; i++)
      do_fetch(VEC[i].addr, VEC[i].cmode, int'(VEC[i].reads), 0, vec_req(i));

    // R7: flush empties every entry
    do_fetch(32'h0000_1000, 1'b0, 0, 0, "R7 before flush");
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_fetch(32'h0000_1000, 1'b0, 1, 0, "R7 miss after flush");
    do_fetch(32'h0000_13FC, 1'b0, 1, 0, "R7 other entry flushed");

    // R8: flush during an outstanding miss drops the fill
    mem_lat  = 3;
    flush_at = 2;
    do_fetch(32'h0000_2000, 1'b0, 1, 0, "R8 miss with flush");
    flush_at = 0;
    do_fetch(32'h0000_2000, 1'b0, 1, 0, "R8 fill was dropped");
    do_fetch(32'h0000_2000, 1'b0, 0, 0, "R8 later fill kept");

    // R12: memory accepts only every other cycle
    stall_mode = 1'b1;
    mem_lat    = 1;
    do_fetch(32'h0000_3042, 1'b1, 2, 0, "R12 split under stall");
    do_fetch(32'h0000_3100, 1'b0, 1, 0, "R12 miss under stall");
    stall_mode = 1'b0;
    mem_lat    = 0;

    // R11: consumer holds off for several cycles
    do_fetch(32'h0000_3100, 1'b0, 0, 3, "R11 hit held");
    do_fetch(32'h0000_3102, 1'b1, 1, 3, "R11 split held");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule